// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a one-bit delay line with a movable read point. On each clock edge where the enable is high, one new bit is pushed in at the head of a chain of storage stages. A tap address picks which stage drives the output. The block can therefore return the bit that entered any chosen number of enabled cycles earlier. The address is live, so the delay can differ from one cycle to the next without reloading any data. Typical uses are a pipeline delay that software or a controller can tune, or an alignment element that matches the latency of two datapaths.

The chain is built from segments of sixteen stages. Each segment behaves like a four-input lookup table used as a shift register. The last stage of each segment feeds the head of the next, and a parameter sets how many segments are chained. The upper address bits choose the segment and the lower four bits choose the stage inside it. The last stage of the whole chain is always available on a separate cascade output, so another instance can extend the delay.

A build-time option places one flip-flop after the tap multiplexer. That flip-flop adds one cycle of delay and gives a registered output. The synchronous reset clears only this output flip-flop. The stored bits are never cleared or preloaded.

Top module: `tapsr_top`

## Requirements
- R1: Stages move only on a rising clock edge with `shift_en` high; with `shift_en` low every stage, and so `chain_out`, keeps its value.
- R2: With no output register, `tap_q` is a combinational read. Address value k returns the bit pushed k+1 enabled edges ago, and a change of address shows on `tap_q` in the same cycle.
- R3: The address may take a different value on every cycle, and reading never disturbs the stored bits.
- R4: `chain_out` always carries the bit pushed N_SEG*16 enabled edges ago, whatever the tap address.
- R5: Segments are chained last stage to head. Address 15 reads the last stage of the first segment, and addresses 16 and above reach the later segments, up to a delay of N_SEG*16.
- R6: With the output register enabled, each enabled edge loads `tap_q` with the combinational tap value from before that edge, so address k gives a delay of k+2 enabled edges. With `shift_en` low, `tap_q` holds.
- R7: A synchronous `rst` drives the registered `tap_q` to 0 on the next edge and takes priority over `shift_en`. The stored bits are unaffected, and shifting goes on during reset when `shift_en` is high.
- R8: `ser_in` has no effect on any stage while `shift_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of the output register only |
| shift_en | input | 1 | Clock enable for the chain and the output register |
| ser_in | input | 1 | Serial data bit pushed at the head |
| tap_addr | input | $clog2(N_SEG*16) | Selects the stage that drives `tap_q` |
| tap_q | output | 1 | Selected stage, combinational or registered per OUT_REG |
| chain_out | output | 1 | Last stage of the whole chain, for cascading |

## Verification
A stage that shifts at the wrong time, or a broken link between segments, shows at the ports in one of two ways. It appears on `tap_q` as soon as the address points at that stage, or it appears on `chain_out` once the wrong bit reaches the end of the chain. Sweeping a fresh address on every cycle exposes a wrong stage within one cycle instead of waiting up to thirty-two cycles for it to drain. A wrong output-register load or reset shows on the first enabled edge after the fault. The bench therefore compares both DUT variants against a history model on every cycle, for fixed patterns, for held-enable runs and for random addresses.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  // stages in one lookup-table style segment
  localparam int unsigned SEG_LEN = 16;
  localparam int unsigned SEG_AW  = $clog2(SEG_LEN);

  function automatic int unsigned chain_len(input int unsigned nseg);
    return nseg * SEG_LEN;
  endfunction
endpackage

// File: rtl/tapsr_segment.sv
module tapsr_segment
  import tapsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              seg_in,
  input  logic [SEG_AW-1:0] seg_addr,
  output logic              seg_tap,
  output logic              seg_last
);
  logic [SEG_LEN-1:0] stage;

  // no reset on contents: maps onto a LUT-based shift register
  always_ff @(posedge clk) begin
    if (shift_en) stage <= {stage[SEG_LEN-2:0], seg_in};
  end

  assign seg_tap  = stage[seg_addr];
  assign seg_last = stage[SEG_LEN-1];

  // R1
  last_moves_chk: assert property (@(posedge clk) disable iff (rst)
    $past(shift_en) |-> (seg_last === $past(stage[SEG_LEN-2])));

  // R8
  hold_all_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(shift_en) |-> (stage === $past(stage)));
endmodule

// File: rtl/tapsr_outreg.sv
module tapsr_outreg (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (shift_en) q <= d;
  end

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (q == 1'b0));

  // R6
  outreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(shift_en) && !$past(rst)) |-> (q === $past(q)));
endmodule

// File: rtl/tapsr_top.sv
module tapsr_top
  import tapsr_pkg::*;
#(
  parameter int unsigned N_SEG   = 2,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned TOTAL  = chain_len(N_SEG),
  localparam int unsigned AW     = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          ser_in,
  input  logic [AW-1:0] tap_addr,
  output logic          tap_q,
  output logic          chain_out
);
  logic [N_SEG-1:0] seg_head;
  logic [N_SEG-1:0] seg_tap;
  logic [N_SEG-1:0] seg_last;
  logic             tap_comb;

  assign seg_head[0] = ser_in;

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    if (s > 0) begin : g_link
      assign seg_head[s] = seg_last[s-1];
    end
    tapsr_segment u_seg (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .seg_in   (seg_head[s]),
      .seg_addr (tap_addr[SEG_AW-1:0]),
      .seg_tap  (seg_tap[s]),
      .seg_last (seg_last[s])
    );
  end

  if (N_SEG == 1) begin : g_one
    assign tap_comb = seg_tap[0];
  end else begin : g_many
    localparam int unsigned SW = AW - SEG_AW;
    logic [SW-1:0] seg_sel;
    assign seg_sel  = tap_addr[AW-1:SEG_AW];
    assign tap_comb = (int'(seg_sel) < int'(N_SEG)) ? seg_tap[seg_sel] : 1'b0;
  end

  assign chain_out = seg_last[N_SEG-1];

  if (OUT_REG) begin : g_reg
    tapsr_outreg u_out (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .d        (tap_comb),
      .q        (tap_q)
    );
  end else begin : g_comb
    assign tap_q = tap_comb;
  end

  // R5
  first_seg_end_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_addr == AW'(SEG_LEN-1)) |-> (tap_comb === seg_last[0]));

  // R4
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(shift_en) |-> (chain_out === $past(chain_out)));
endmodule

// File: tb/sim_tapsr_top.sv
module sim_tapsr_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NSEG  = 2;
  localparam int unsigned TOT   = NSEG * 16;
  localparam int unsigned AWB   = $clog2(TOT);
  localparam int unsigned NVEC  = 16;
  // {ser_in, shift_en, tap_addr}
  localparam logic [AWB+1:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 5'd0},  {1'b0, 1'b1, 5'd0},  {1'b1, 1'b1, 5'd1},
    {1'b1, 1'b1, 5'd15}, {1'b0, 1'b1, 5'd16}, {1'b0, 1'b1, 5'd31},
    {1'b1, 1'b0, 5'd2},  {1'b0, 1'b0, 5'd3},  {1'b1, 1'b1, 5'd30},
    {1'b0, 1'b1, 5'd14}, {1'b1, 1'b1, 5'd17}, {1'b1, 1'b1, 5'd5},
    {1'b0, 1'b0, 5'd15}, {1'b0, 1'b1, 5'd16}, {1'b1, 1'b1, 5'd8},
    {1'b0, 1'b1, 5'd0}
  };

  logic clk = 1'b0;
  logic rst, en, din;
  logic [AWB-1:0] addr;
  logic tap_c, casc_c, tap_r, casc_r;
  logic [TOT-1:0] hist;
  logic q_mod;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tapsr_top #(.N_SEG(NSEG), .OUT_REG(1'b0)) u0 (
    .clk(clk), .rst(rst), .shift_en(en), .ser_in(din),
    .tap_addr(addr), .tap_q(tap_c), .chain_out(casc_c));

  tapsr_top #(.N_SEG(NSEG), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst(rst), .shift_en(en), .ser_in(din),
    .tap_addr(addr), .tap_q(tap_r), .chain_out(casc_r));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check before the edge, then advance the model
  task automatic tick(input logic r, input logic c, input logic d,
                      input logic [AWB-1:0] a, input bit chk, input string tag);
    @(negedge clk);
    rst = r; en = c; din = d; addr = a;
    #1;
    if (chk) begin
      check({tag, " R2 comb tap"}, tap_c, hist[a]);
      check({tag, " R4 chain_out"}, casc_c, hist[TOT-1]);
      check({tag, " R6 registered tap"}, tap_r, q_mod);
    end
    @(posedge clk);
    if (r)      q_mod = 1'b0;
    else if (c) q_mod = hist[a];
    if (c) hist = {hist[TOT-2:0], d};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hist = 'x; q_mod = 1'b0;
    rst = 1'b1; en = 1'b0; din = 1'b0; addr = '0;
    repeat (3) @(posedge clk);
    tick(1'b0, 1'b0, 1'b0, '0, 1'b0, "");
    check("R7 reset clears registered tap", tap_r, 1'b0);
    // prefill the whole chain so the model is fully known
    for (int i = 0; i < TOT + 1; i++)
      tick(1'b0, 1'b1, 1'((i * 7 + 3) % 5 == 0), AWB'(i), 1'b0, "");
    // table walk
    for (int i = 0; i < NVEC; i++)
      tick(1'b0, VEC[i][AWB], VEC[i][AWB+1], VEC[i][AWB-1:0], 1'b1, "R1 R5 table");
    // R5: boundary addresses 15, 16 and the deepest stage
    tick(1'b0, 1'b1, 1'b1, 5'd15, 1'b1, "R5 addr15");
    tick(1'b0, 1'b1, 1'b0, 5'd16, 1'b1, "R5 addr16");
    tick(1'b0, 1'b1, 1'b1, AWB'(TOT-1), 1'b1, "R5 deepest");
    // R1, R8: enable low, din toggling, address sweep reads unchanged state
    for (int i = 0; i < TOT; i++)
      tick(1'b0, 1'b0, 1'(i), AWB'(i), 1'b1, "R8 hold");
    // R7: reset with enable high clears the register, contents still shift
    tick(1'b1, 1'b1, 1'b1, 5'd4, 1'b1, "R7 pre");
    tick(1'b0, 1'b1, 1'b0, 5'd4, 1'b1, "R7 post");
    check("R7 registered tap zero after reset", tap_r, 1'b0);
    // R3: random address every cycle
    for (int i = 0; i < 400; i++)
      tick(1'b0, 1'(($urandom % 4) != 0), 1'($urandom), AWB'($urandom),
           1'b1, "R3 random");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule